// File: doc/BRIEF.md
# Memory PHY Bring-up Init Sequencer

This block brings a DRAM controller and its PHY from reset to a trained, usable state. It leaves reset on its own and walks a fixed chain of stages. The stages are clock/PLL readiness, DFI initialization, ZQ calibration, MDLL lock, scheduler enable and the hand-off to the training scheduler. In each stage it drives a request toward a sub-unit and polls that sub-unit's status before it moves on. Only one stage is active at a time. A status input has effect only in the stage that owns it.

Every waiting stage is guarded by a cycle-count timeout. The limit comes from an input, and a limit of zero turns the timeout off. When the limit runs out, the sequencer stops and drops all requests. It raises a sticky error flag and holds a code that names the stage that hung. When training reports completion, a sticky ready output goes high.

The scheduler stage uses a two-phase poll. After enabling the scheduler, the sequencer waits for a busy status to go high and then waits for it to fall back low.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset every output is low, and no request leaves the block until `clk_ready` has been sampled high.
- R2: `dfi_init_start` rises one cycle after `clk_ready` is sampled high. It stays high until `dfi_init_complete` is sampled high and falls in the next cycle.
- R3: `zq_start` is a single-cycle pulse, issued in the cycle in which `dfi_init_start` falls. The sequencer then waits for `zq_done`.
- R4: `sched_en` rises only after `zq_done` has been seen and, in a later cycle, `mdll_locked` has been sampled high. It stays high through the rest of the chain and afterwards.
- R5: After `sched_en` rises, the sequencer waits for `sched_busy` to be sampled high. It then waits for `sched_busy` to be sampled low, and `train_start` stays low throughout this wait.
- R6: `train_start` rises one cycle after `sched_busy` is sampled low in the second phase. It stays high until `train_done` is sampled high.
- R7: One cycle after `train_done` is sampled high, `ready` rises and `train_start` falls. `ready` then stays high until reset.
- R8: If a waiting stage sees no completion for `timeout_limit`+1 cycles, the block goes to error. `err_flag` rises, and `dfi_init_start`, `zq_start`, `sched_en` and `train_start` go low. `err_step` holds the stage code: 1 clock, 2 DFI, 3 ZQ, 4 MDLL, 5 busy-rise, 6 busy-fall, 7 training. Both outputs hold until reset, and later inputs are ignored.
- R9: A `timeout_limit` of zero disables the timeout, and the block then waits without limit.
- R10: A status input pulsed while its stage is not active is ignored. For example, an early `zq_done` does not satisfy the ZQ stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_limit | input | TMO_W | Per-stage wait limit in cycles; 0 disables |
| clk_ready | input | 1 | Power, PLL and clock configuration complete |
| dfi_init_start | output | 1 | DFI initialization request, held level |
| dfi_init_complete | input | 1 | DFI initialization finished |
| zq_start | output | 1 | ZQ calibration manual-start pulse |
| zq_done | input | 1 | ZQ calibration finished |
| mdll_locked | input | 1 | Master DLL locked |
| sched_en | output | 1 | Scheduler enable |
| sched_busy | input | 1 | Scheduler handshake status (high, then low) |
| train_start | output | 1 | Training scheduler start, held level |
| train_done | input | 1 | Training scheduler finished |
| ready | output | 1 | Bring-up complete, sticky |
| err_flag | output | 1 | Timeout error, sticky |
| err_step | output | 3 | Code of the stage that timed out |

## Verification
If the stage register were wrong, a request strobe would show up out of order, or a stage would be skipped. The first request after the bad state exposes it within one cycle. A timeout counter that is not cleared at each stage entry would move `err_flag` by one or more cycles, so the bench probes the cycle before and the cycle of expiry. A wrongly latched stage code appears directly on `err_step` in the cycle the flag rises.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  localparam int unsigned CODE_W = 3;

  typedef enum logic [3:0] {
    ST_CLK      = 4'd0,
    ST_DFI      = 4'd1,
    ST_ZQ_KICK  = 4'd2,
    ST_ZQ_WAIT  = 4'd3,
    ST_MDLL     = 4'd4,
    ST_SCH_RISE = 4'd5,
    ST_SCH_FALL = 4'd6,
    ST_TRAIN    = 4'd7,
    ST_DONE     = 4'd8,
    ST_ERR      = 4'd9
  } seq_state_e;

  // Stage code reported on a timeout; 0 means no failing stage.
  function automatic logic [CODE_W-1:0] stage_code(seq_state_e s);
    case (s)
      ST_CLK:      return 3'd1;
      ST_DFI:      return 3'd2;
      ST_ZQ_WAIT:  return 3'd3;
      ST_MDLL:     return 3'd4;
      ST_SCH_RISE: return 3'd5;
      ST_SCH_FALL: return 3'd6;
      ST_TRAIN:    return 3'd7;
      default:     return 3'd0;
    endcase
  endfunction

  function automatic logic is_wait(seq_state_e s);
    return stage_code(s) != 3'd0;
  endfunction

endpackage

// File: rtl/bringup_wdog.sv
module bringup_wdog #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  logic [TMO_W-1:0] cnt_q;
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (limit != '0) && (cnt_q >= limit);

endmodule

// File: rtl/bringup_ctrl.sv
module bringup_ctrl
  import phy_bringup_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_ready,
  input  logic              dfi_init_complete,
  input  logic              zq_done,
  input  logic              mdll_locked,
  input  logic              sched_busy,
  input  logic              train_done,
  input  logic              wd_expired,
  output logic              wd_run,
  output logic              wd_clear,
  output logic              dfi_init_start,
  output logic              zq_start,
  output logic              sched_en,
  output logic              train_start,
  output logic              ready,
  output logic              err_flag,
  output logic [CODE_W-1:0] err_step
);

  seq_state_e state_q, state_d;
  logic       progress;

  always_comb begin
    progress = 1'b0;
    case (state_q)
      ST_CLK:      progress = clk_ready;
      ST_DFI:      progress = dfi_init_complete;
      ST_ZQ_KICK:  progress = 1'b1;
      ST_ZQ_WAIT:  progress = zq_done;
      ST_MDLL:     progress = mdll_locked;
      ST_SCH_RISE: progress = sched_busy;
      ST_SCH_FALL: progress = !sched_busy;
      ST_TRAIN:    progress = train_done;
      default:     progress = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (progress) begin
      case (state_q)
        ST_CLK:      state_d = ST_DFI;
        ST_DFI:      state_d = ST_ZQ_KICK;
        ST_ZQ_KICK:  state_d = ST_ZQ_WAIT;
        ST_ZQ_WAIT:  state_d = ST_MDLL;
        ST_MDLL:     state_d = ST_SCH_RISE;
        ST_SCH_RISE: state_d = ST_SCH_FALL;
        ST_SCH_FALL: state_d = ST_TRAIN;
        ST_TRAIN:    state_d = ST_DONE;
        default:     state_d = state_q;
      endcase
    end else if (wd_run && wd_expired) begin
      state_d = ST_ERR;
    end
  end

  assign wd_run   = is_wait(state_q);
  assign wd_clear = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_CLK;
      dfi_init_start <= 1'b0;
      zq_start       <= 1'b0;
      sched_en       <= 1'b0;
      train_start    <= 1'b0;
      ready          <= 1'b0;
      err_flag       <= 1'b0;
      err_step       <= '0;
    end else begin
      state_q        <= state_d;
      dfi_init_start <= (state_d == ST_DFI);
      zq_start       <= (state_d == ST_ZQ_KICK);
      sched_en       <= (state_d == ST_SCH_RISE) || (state_d == ST_SCH_FALL) ||
                        (state_d == ST_TRAIN)    || (state_d == ST_DONE);
      train_start    <= (state_d == ST_TRAIN);
      ready          <= (state_d == ST_DONE);
      err_flag       <= (state_d == ST_ERR);
      if (state_d == ST_ERR && state_q != ST_ERR) begin
        err_step <= stage_code(state_q);
      end
    end
  end

  // Assertions, next to the handshake logic they guard.
  p_dfi_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (dfi_init_start && !dfi_init_complete && !wd_expired) |=> dfi_init_start);

  p_zq_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    zq_start |=> !zq_start);

  p_sched_order_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sched_en) |-> $past(mdll_locked));

  p_train_order_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(train_start) |-> ($past(!sched_busy) && sched_en));

  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (!dfi_init_start && !zq_start && !sched_en && !train_start && !ready));

  p_err_code_r8: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> (err_flag && $stable(err_step) && err_step != '0));

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TMO_W-1:0]  timeout_limit,
  input  logic              clk_ready,
  output logic              dfi_init_start,
  input  logic              dfi_init_complete,
  output logic              zq_start,
  input  logic              zq_done,
  input  logic              mdll_locked,
  output logic              sched_en,
  input  logic              sched_busy,
  output logic              train_start,
  input  logic              train_done,
  output logic              ready,
  output logic              err_flag,
  output logic [CODE_W-1:0] err_step
);

  logic wd_run, wd_clear, wd_expired;

  bringup_wdog #(.TMO_W(TMO_W)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .clear   (wd_clear),
    .run     (wd_run),
    .limit   (timeout_limit),
    .expired (wd_expired)
  );

  bringup_ctrl u_ctrl (
    .clk               (clk),
    .rst               (rst),
    .clk_ready         (clk_ready),
    .dfi_init_complete (dfi_init_complete),
    .zq_done           (zq_done),
    .mdll_locked       (mdll_locked),
    .sched_busy        (sched_busy),
    .train_done        (train_done),
    .wd_expired        (wd_expired),
    .wd_run            (wd_run),
    .wd_clear          (wd_clear),
    .dfi_init_start    (dfi_init_start),
    .zq_start          (zq_start),
    .sched_en          (sched_en),
    .train_start       (train_start),
    .ready             (ready),
    .err_flag          (err_flag),
    .err_step          (err_step)
  );

  p_no_req_before_clk_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(dfi_init_start) |-> $past(clk_ready));

  p_limit_off_r9: assert property (@(posedge clk) disable iff (rst)
    (timeout_limit == '0 && !err_flag) |=> !err_flag);

endmodule

// File: tb/phy_bringup_seq_test.sv
module phy_bringup_seq_test;

  localparam int unsigned TMO_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [TMO_W-1:0] timeout_limit = '0;
  logic clk_ready = 1'b0, dfi_init_complete = 1'b0, zq_done = 1'b0;
  logic mdll_locked = 1'b0, sched_busy = 1'b0, train_done = 1'b0;
  logic dfi_init_start, zq_start, sched_en, train_start, ready, err_flag;
  logic [2:0] err_step;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  phy_bringup_seq #(.TMO_W(TMO_W)) uut (
    .clk(clk), .rst(rst), .timeout_limit(timeout_limit),
    .clk_ready(clk_ready), .dfi_init_start(dfi_init_start),
    .dfi_init_complete(dfi_init_complete), .zq_start(zq_start),
    .zq_done(zq_done), .mdll_locked(mdll_locked), .sched_en(sched_en),
    .sched_busy(sched_busy), .train_start(train_start),
    .train_done(train_done), .ready(ready), .err_flag(err_flag),
    .err_step(err_step)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [TMO_W-1:0] lim);
    @(negedge clk);
    rst = 1'b1; timeout_limit = lim;
    clk_ready = 0; dfi_init_complete = 0; zq_done = 0;
    mdll_locked = 0; sched_busy = 0; train_done = 0;
    tick(3);
    rst = 1'b0;
  endtask

  // Walks to the second phase of the scheduler handshake (busy held high).
  task automatic walk_to_busy_fall();
    clk_ready = 1; tick(1);
    dfi_init_complete = 1; tick(1); dfi_init_complete = 0;
    tick(1);
    zq_done = 1; tick(1); zq_done = 0;
    mdll_locked = 1; tick(1);
    sched_busy = 1; tick(1);
  endtask

  task automatic t_reset_and_wait();
    do_reset('0);
    chk("R1 dfi_init_start after reset", dfi_init_start, 0);
    chk("R1 outputs after reset", {zq_start, sched_en, train_start, ready, err_flag}, 0);
    dfi_init_complete = 1; zq_done = 1; mdll_locked = 1;
    tick(300);
    chk("R1 no request without clk_ready", {dfi_init_start, zq_start, sched_en}, 0);
    chk("R9 no timeout with limit zero", err_flag, 0);
  endtask

  task automatic t_nominal();
    do_reset(16'd50);
    tick(5);
    chk("R1 wait for clk_ready", dfi_init_start, 0);
    clk_ready = 1; tick(1);
    chk("R2 dfi_init_start rises", dfi_init_start, 1);
    tick(3);
    chk("R2 dfi_init_start held", dfi_init_start, 1);
    dfi_init_complete = 1; tick(1); dfi_init_complete = 0;
    chk("R2 dfi_init_start falls", dfi_init_start, 0);
    chk("R3 zq_start pulse", zq_start, 1);
    tick(1);
    chk("R3 zq_start one cycle", zq_start, 0);
    mdll_locked = 1;
    tick(4);
    chk("R4 sched_en waits for zq_done", sched_en, 0);
    zq_done = 1; tick(1); zq_done = 0;
    chk("R4 sched_en after mdll stage only", sched_en, 0);
    tick(1);
    chk("R4 sched_en rises", sched_en, 1);
    tick(3);
    chk("R5 waiting for busy rise", train_start, 0);
    sched_busy = 1; tick(3);
    chk("R5 waiting for busy fall", train_start, 0);
    sched_busy = 0; tick(1);
    chk("R6 train_start rises", train_start, 1);
    tick(3);
    chk("R6 train_start held", {train_start, ready}, 2'b10);
    train_done = 1; tick(1); train_done = 0;
    chk("R7 ready rises", ready, 1);
    chk("R7 train_start falls", train_start, 0);
    tick(10);
    chk("R7 ready sticky", ready, 1);
    chk("R4 sched_en held", sched_en, 1);
    chk("R8 no error on nominal run", err_flag, 0);
  endtask

  task automatic t_timeout_dfi();
    do_reset(16'd8);
    clk_ready = 1; tick(1);
    chk("R2 dfi_init_start before timeout", dfi_init_start, 1);
    tick(8);
    chk("R8 no error at limit", err_flag, 0);
    tick(1);
    chk("R8 error flag at limit+1", err_flag, 1);
    chk("R8 stage code DFI", err_step, 2);
    chk("R8 dfi_init_start dropped", dfi_init_start, 0);
    dfi_init_complete = 1; tick(5);
    chk("R8 error sticky", {err_flag, zq_start, err_step}, {1'b1, 1'b0, 3'd2});
  endtask

  task automatic t_timeout_clk();
    do_reset(16'd4);
    tick(10);
    chk("R8 stage code clock", {err_flag, err_step}, {1'b1, 3'd1});
    clk_ready = 1; tick(2);
    chk("R8 no request after error", dfi_init_start, 0);
  endtask

  task automatic t_timeout_busy_fall();
    do_reset(16'd5);
    walk_to_busy_fall();
    tick(10);
    chk("R8 stage code busy-fall", {err_flag, err_step}, {1'b1, 3'd6});
    chk("R8 sched_en dropped", sched_en, 0);
    sched_busy = 0; tick(2);
    chk("R8 no train after error", train_start, 0);
  endtask

  task automatic t_ignore_early();
    do_reset('0);
    clk_ready = 1; tick(2);
    zq_done = 1; tick(1); zq_done = 0;
    chk("R10 zq_done ignored in DFI stage", {dfi_init_start, zq_start}, 2'b10);
    dfi_init_complete = 1; tick(1); dfi_init_complete = 0;
    chk("R3 zq_start after early zq_done", zq_start, 1);
    mdll_locked = 1; tick(6);
    chk("R10 early zq_done not latched", sched_en, 0);
    zq_done = 1; tick(1); zq_done = 0; tick(1);
    chk("R10 fresh zq_done accepted", sched_en, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1-chain: watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_and_wait();
    t_nominal();
    t_timeout_dfi();
    t_timeout_clk();
    t_timeout_busy_fall();
    t_ignore_early();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule